// File: doc/BRIEF.md
# Self-Modifying Descriptor Queue Engine

This block executes short programs made of 64-bit descriptors. The descriptors sit in a circular queue at the bottom of one word-addressed memory, and operand data sits in the same memory above them. One engine consumes descriptors one at a time. It can write a constant, copy a word, run a 48-bit compare-and-swap, wait for an earlier descriptor to complete, or refill its own execution allowance. Descriptors and data share one address space, so a compare-and-swap can rewrite the opcode of a descriptor that comes later in the queue. This gives data-dependent branches, and a refilled allowance combined with pointer wraparound gives loops.

The host loads descriptors and data through a simple write port while the engine is idle. It then rings a doorbell that grants a number of execution credits. Every executed descriptor produces a one-cycle completion pulse that carries its queue index and a result word. A `managed` input selects strict mode, in which each descriptor is read from memory at the moment it executes. In the default mode the engine reads the following descriptor early, in the same cycle as the current one.

Descriptor layout: bits [3:0] hold the opcode (0 no-op, 1 store-constant, 2 copy, 3 compare-and-swap, 4 wait, 5 refill). Bits [15:4] hold address A, bits [27:16] hold address B and bits [63:28] hold a 36-bit count/constant. Only the low `AW` bits of an address are used. Queue slots occupy addresses 0 to `QDEPTH-1`.

Top module: `wq_engine`

## Requirements
- R1: After reset, `busy` is 0, `cpl_valid` is 0, `err` is 0, the queue pointer is at slot 0 and no descriptor has completed yet.
- R2: While the credit count is zero, no descriptor executes and `busy` is 0. A `db_valid` pulse adds `db_count` to the credits on the next edge.
- R3: Each executed descriptor uses one credit. A refill descriptor (opcode 5) instead sets the credits to the low `CW` bits of its count field. A doorbell in that same cycle is added on top of that value.
- R4: A descriptor that executes at one edge gives `cpl_valid`=1 for exactly the following cycle, with `cpl_idx` set to its slot. `cpl_data` is 0 unless R6 or R7 define it.
- R5: Store-constant (opcode 1) writes the zero-extended 36-bit count field into word A.
- R6: Copy (opcode 2) writes word A into word B and returns word A on `cpl_data`.
- R7: Compare-and-swap (opcode 3) compares bits [47:0] of word A with bits [47:0] of word B. On a match it replaces bits [47:0] of word A with bits [47:0] of word B+1 and keeps bits [63:48]. It always returns the old word A on `cpl_data`.
- R8: With `managed`=1, a descriptor rewritten by the descriptor just before it runs in its new form. With `managed`=0, the descriptor right after an executing one runs as it was before that execution. Descriptors further ahead always see the rewrite.
- R9: Wait (opcode 4) executes only when the last completed slot equals bits [QW+3:4] of the descriptor. Until then nothing completes, no credit is used and `busy` stays 1.
- R10: After slot `QDEPTH-1` the pointer wraps to slot 0.
- R11: An opcode above 5 behaves as a no-op and sets `err`, which stays 1 until reset.
- R12: `host_rdata` always shows the word at `host_addr`. A host write is applied only while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| managed | input | 1 | 1 selects strict fetch, 0 allows early read of the next descriptor |
| db_valid | input | 1 | Doorbell pulse |
| db_count | input | CW | Credits granted by the doorbell |
| host_we | input | 1 | Host write strobe |
| host_addr | input | AW | Host word address |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Word at host_addr |
| cpl_valid | output | 1 | Completion pulse |
| cpl_idx | output | QW | Slot of the completed descriptor |
| cpl_data | output | 64 | Result word of the completed descriptor |
| busy | output | 1 | Credits remain |
| err | output | 1 | Sticky undefined-opcode flag |

## Verification
Two collisions matter. The first is a doorbell that arrives in the same cycle as a refill descriptor executes. The bench rings the second doorbell exactly one cycle after the first, so that it coincides with the refill at slot 0. It then judges the outcome by whether a store-constant three slots later takes effect, which needs the sum of both credits. The second is a compare-and-swap that rewrites its own successor in the same cycle the successor is read early. The bench runs this in both modes and compares the target word with the stale and the fresh expectation. A cycle-accurate behavioural model in the bench also compares every output on every clock.

// File: rtl/wq_engine.sv
module wq_engine #(
  parameter int AW = 8,
  parameter int QDEPTH = 8,
  parameter int CW = 16,
  localparam int QW = $clog2(QDEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          managed,
  input  logic          db_valid,
  input  logic [CW-1:0] db_count,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [63:0]   host_wdata,
  output logic [63:0]   host_rdata,
  output logic          cpl_valid,
  output logic [QW-1:0] cpl_idx,
  output logic [63:0]   cpl_data,
  output logic          busy,
  output logic          err
);
  localparam logic [3:0] OP_NOP = 4'd0, OP_PUT = 4'd1, OP_CPY = 4'd2,
                         OP_CAS = 4'd3, OP_WAIT = 4'd4, OP_FILL = 4'd5;
  localparam logic [QW-1:0] LAST = QW'(QDEPTH - 1);

  logic [63:0]   mem [1<<AW];
  logic [QW-1:0] head, last_idx;
  logic [CW-1:0] credits;
  logic          pf_v, last_v;
  logic [63:0]   pf_d;

  wire [63:0]   desc = (!managed && pf_v) ? pf_d : mem[AW'(head)];
  wire [3:0]    op   = desc[3:0];
  wire [AW-1:0] a    = desc[4 +: AW];
  wire [AW-1:0] b    = desc[16 +: AW];
  wire [35:0]   cnt  = desc[63:28];
  wire [AW-1:0] b1   = b + AW'(1);
  wire [QW-1:0] nxt  = (head == LAST) ? '0 : head + QW'(1);
  wire [63:0]   wa   = mem[a];
  wire [63:0]   wb   = mem[b];
  wire [63:0]   wb1  = mem[b1];
  wire          hit  = wa[47:0] == wb[47:0];
  wire          wait_ok = last_v && (last_idx == desc[4 +: QW]);
  wire          go   = (credits != '0) && (op != OP_WAIT || wait_ok);
  wire [CW-1:0] base = !go ? credits : (op == OP_FILL) ? cnt[CW-1:0] : credits - CW'(1);

  logic unused_bits;
  assign unused_bits = ^{desc[15:4], desc[27:16], wb[63:48], wb1[63:48]};

  assign busy = credits != '0;
  assign host_rdata = mem[host_addr];

  always_ff @(posedge clk) begin
    if (go && op == OP_PUT) mem[a] <= {28'b0, cnt};
    else if (go && op == OP_CPY) mem[b] <= wa;
    else if (go && op == OP_CAS && hit) mem[a] <= {wa[63:48], wb1[47:0]};
    else if (host_we && !busy) mem[host_addr] <= host_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head      <= '0;
      credits   <= '0;
      pf_v      <= 1'b0;
      pf_d      <= '0;
      last_v    <= 1'b0;
      last_idx  <= '0;
      cpl_valid <= 1'b0;
      cpl_idx   <= '0;
      cpl_data  <= '0;
      err       <= 1'b0;
    end else begin
      credits   <= base + (db_valid ? db_count : '0);
      pf_v      <= go;
      pf_d      <= mem[AW'(nxt)];
      cpl_valid <= go;
      if (go) begin
        head     <= nxt;
        last_v   <= 1'b1;
        last_idx <= head;
        cpl_idx  <= head;
        cpl_data <= (op == OP_CPY || op == OP_CAS) ? wa : '0;
        if (op > OP_FILL) err <= 1'b1;
      end
    end
  end

  AST_IDLE_NO_CPL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !cpl_valid); // R2
  AST_CPL_HAD_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> $past(busy)); // R3
  AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && $past(cpl_valid)) |->
      cpl_idx == (($past(cpl_idx) == LAST) ? '0 : $past(cpl_idx) + QW'(1))); // R10
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op == OP_WAIT && !wait_ok) |=> (busy && !cpl_valid)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R11
  AST_NOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == OP_NOP) |=> (cpl_valid && cpl_data == '0)); // R4
endmodule

// File: tb/sim_wq_engine.sv
module sim_wq_engine;
  localparam int AW = 8, QD = 8, CW = 16, QW = 3;
  logic clk = 0, rst_n = 0, managed = 0, db_valid = 0, host_we = 0;
  logic [CW-1:0] db_count = '0;
  logic [AW-1:0] host_addr = '0;
  logic [63:0] host_wdata = '0, host_rdata, cpl_data;
  logic cpl_valid, busy, err;
  logic [QW-1:0] cpl_idx;
  int checks = 0, errors = 0;
  bit cmp_on = 0, done = 0;

  wq_engine #(.AW(AW), .QDEPTH(QD), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .managed(managed), .db_valid(db_valid), .db_count(db_count),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cpl_valid(cpl_valid), .cpl_idx(cpl_idx), .cpl_data(cpl_data), .busy(busy), .err(err));

  always #5 clk = ~clk;

  // behavioural reference state
  logic [63:0] mm [256];
  int m_head = 0, m_cred = 0, m_last = 0;
  bit m_pfv = 0, m_lastv = 0, m_err = 0, m_cv = 0;
  logic [63:0] m_pfd = 0, m_cd = 0;
  int m_ci = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] dsc(input int op, input int a, input int b, input longint c);
    logic [63:0] w;
    w = '0;
    w[3:0] = op[3:0]; w[15:4] = a[11:0]; w[27:16] = b[11:0]; w[63:28] = c[35:0];
    return w;
  endfunction

  task automatic model_step();
    logic [63:0] d, wa, wb, wb1, pfn;
    int op, a, b, nx, base;
    bit go, ok;
    d = (!managed && m_pfv) ? m_pfd : mm[m_head];
    op = int'(d[3:0]); a = int'(d[4 +: AW]); b = int'(d[16 +: AW]);
    ok = m_lastv && (m_last == int'(d[4 +: QW]));
    go = (m_cred != 0) && (op != 4 || ok);
    nx = (m_head + 1) % QD;
    wa = mm[a]; wb = mm[b]; wb1 = mm[(b + 1) % 256]; pfn = mm[nx];
    if (!go) base = m_cred; else if (op == 5) base = int'(d[28 +: CW]); else base = m_cred - 1;
    if (go && op == 1) mm[a] = {28'b0, d[63:28]};
    else if (go && op == 2) mm[b] = wa;
    else if (go && op == 3 && wa[47:0] == wb[47:0]) mm[a] = {wa[63:48], wb1[47:0]};
    else if (host_we && m_cred == 0) mm[host_addr] = host_wdata;
    if (!rst_n) begin
      m_head = 0; m_cred = 0; m_pfv = 0; m_lastv = 0; m_err = 0; m_cv = 0;
    end else begin
      m_cred = (base + (db_valid ? int'(db_count) : 0)) % (1 << CW);
      m_pfv = go; m_pfd = pfn; m_cv = go;
      if (go) begin
        m_ci = m_head; m_cd = (op == 2 || op == 3) ? wa : 64'h0;
        m_lastv = 1; m_last = m_head; m_head = nx;
        if (op > 5) m_err = 1;
      end
    end
  endtask

  task automatic cyc();
    model_step();
    @(negedge clk);
    if (cmp_on) begin
      chk(busy == (m_cred != 0), "R2 busy", 64'(busy), 64'(m_cred != 0));
      chk(cpl_valid == m_cv, "R4 cpl_valid", 64'(cpl_valid), 64'(m_cv));
      if (m_cv) begin
        chk(cpl_idx == QW'(m_ci), "R10 cpl_idx", 64'(cpl_idx), 64'(m_ci));
        chk(cpl_data == m_cd, "R7 cpl_data", cpl_data, m_cd);
      end
      chk(err == m_err, "R11 err", 64'(err), 64'(m_err));
      chk(host_rdata == mm[host_addr], "R12 host_rdata", host_rdata, mm[host_addr]);
    end
  endtask

  task automatic hw(input int addr, input logic [63:0] data);
    host_we = 1; host_addr = AW'(addr); host_wdata = data;
    cyc();
    host_we = 0;
  endtask

  task automatic peek(input int addr, output logic [63:0] v);
    host_addr = AW'(addr);
    #1 v = host_rdata;
  endtask

  task automatic ring(input int n);
    db_valid = 1; db_count = CW'(n);
    cyc();
    db_valid = 0; db_count = '0;
  endtask

  task automatic do_reset();
    rst_n = 0; cyc(); cyc(); rst_n = 1; cyc();
    chk(busy == 0 && cpl_valid == 0 && err == 0, "R1 reset outputs",
        {61'b0, busy, cpl_valid, err}, 64'h0);
  endtask

  task automatic clear_q();
    for (int i = 0; i < QD; i++) hw(i, 64'h0);
  endtask

  task automatic run_idle();
    for (int i = 0; i < 60 && busy; i++) cyc();
    cyc(); cyc();
  endtask

  task automatic wait_cpl(output int idx, output logic [63:0] dat);
    idx = -1; dat = '0;
    for (int i = 0; i < 30; i++) begin
      cyc();
      if (cpl_valid) begin idx = int'(cpl_idx); dat = cpl_data; return; end
    end
    chk(0, "R4 completion missing", 0, 1);
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    int idx;
    logic [63:0] dat;
    for (int i = 0; i < 256; i++) mm[i] = '0;
    @(negedge clk);
    do_reset();
    for (int i = 0; i < 256; i++) hw(i, 64'h0);
    cmp_on = 1;
    do_reset();

    // R2 / R5: nothing runs without credits, then two stores
    hw(0, dsc(1, 'h40, 0, 'h123)); hw(1, dsc(1, 'h41, 0, 5));
    for (int i = 0; i < 6; i++) cyc();
    peek('h40, v); chk(v == 0, "R2 no fetch before doorbell", v, 0);
    ring(2); run_idle();
    peek('h40, v); chk(v == 64'h123, "R5 store word A", v, 64'h123);
    peek('h41, v); chk(v == 64'h5, "R5 second store", v, 64'h5);
    chk(busy == 0, "R3 credits exhausted", 64'(busy), 0);

    // R6 / R7: copy, matching CAS, failing CAS
    do_reset(); clear_q();
    hw(0, dsc(2, 'h40, 'h50, 0));
    hw(1, dsc(3, 'h60, 'h61, 0));
    hw(2, dsc(3, 'h60, 'h61, 0));
    hw('h60, 64'hABCD_0000_0000_0007); hw('h61, 64'h7); hw('h62, 64'hFFFF_0000_0000_0009);
    ring(3);
    wait_cpl(idx, dat); chk(idx == 0 && dat == 64'h123, "R6 copy returns word A", dat, 64'h123);
    wait_cpl(idx, dat); chk(dat == 64'hABCD_0000_0000_0007, "R7 CAS old value on match", dat, 64'hABCD_0000_0000_0007);
    wait_cpl(idx, dat); chk(dat == 64'hABCD_0000_0000_0009, "R7 CAS old value on miss", dat, 64'hABCD_0000_0000_0009);
    run_idle();
    peek('h50, v); chk(v == 64'h123, "R6 copy into word B", v, 64'h123);
    peek('h60, v); chk(v == 64'hABCD_0000_0000_0009, "R7 swap keeps upper bits", v, 64'hABCD_0000_0000_0009);

    // R8: branch by rewriting the next descriptor, default mode (stale)
    do_reset(); clear_q();
    hw(0, dsc(3, 1, 'h70, 0)); hw(1, dsc(0, 'h42, 0, 'h77));
    hw('h70, dsc(0, 'h42, 0, 'h77)); hw('h71, dsc(1, 'h42, 0, 'h77));
    managed = 0; ring(2); run_idle();
    peek('h42, v); chk(v == 0, "R8 default mode runs stale successor", v, 0);
    peek(1, v); chk(v[3:0] == 4'd1, "R8 successor rewritten in memory", 64'(v[3:0]), 1);
    // managed mode sees it
    do_reset(); clear_q();
    hw(0, dsc(3, 1, 'h70, 0)); hw(1, dsc(0, 'h42, 0, 'h77));
    managed = 1; ring(2); run_idle(); managed = 0;
    peek('h42, v); chk(v == 64'h77, "R8 managed mode runs new form", v, 64'h77);
    // default mode, target two slots ahead
    do_reset(); clear_q();
    hw(0, dsc(3, 2, 'h72, 0)); hw(2, dsc(0, 'h43, 0, 'h55));
    hw('h72, dsc(0, 'h43, 0, 'h55)); hw('h73, dsc(1, 'h43, 0, 'h55));
    ring(3); run_idle();
    peek('h43, v); chk(v == 64'h55, "R8 far rewrite seen in default mode", v, 64'h55);

    // R3: refill sets credits
    do_reset(); clear_q();
    hw(0, dsc(5, 0, 0, 2)); hw(3, dsc(1, 'h45, 0, 'hAA));
    ring(1); run_idle();
    peek('h45, v); chk(v == 0, "R3 refill limits run", v, 0);
    // R3: doorbell in the same cycle the refill executes
    do_reset();
    ring(1); ring(1); run_idle();
    peek('h45, v); chk(v == 64'hAA, "R3 refill plus same-cycle doorbell", v, 64'hAA);

    // R10: wraparound
    do_reset(); clear_q();
    ring(10);
    for (int i = 0; i < 10; i++) begin
      wait_cpl(idx, dat);
      chk(idx == i % QD, "R10 slot sequence wraps", 64'(idx), 64'(i % QD));
    end
    run_idle(); ring(1); wait_cpl(idx, dat);
    chk(idx == 2, "R10 pointer continues after wrap", 64'(idx), 2);

    // R9 / R12: wait on completed slot, then a blocking wait
    do_reset(); clear_q();
    hw('h46, 64'h0);
    hw(1, dsc(4, 0, 0, 0)); hw(2, dsc(4, 0, 0, 0)); hw(3, dsc(1, 'h46, 0, 'h31));
    ring(4);
    wait_cpl(idx, dat); wait_cpl(idx, dat);
    chk(idx == 1, "R9 satisfied wait completes", 64'(idx), 1);
    begin
      int seen = 0;
      for (int i = 0; i < 12; i++) begin cyc(); if (cpl_valid) seen++; end
      chk(seen == 0 && busy == 1, "R9 unsatisfied wait holds", 64'(seen), 0);
    end
    hw('h46, 64'h99);
    peek('h46, v); chk(v == 0, "R12 host write ignored while busy", v, 0);

    // R11: undefined opcode
    do_reset(); clear_q();
    hw(0, 64'hE);
    ring(2); run_idle();
    chk(err == 1, "R11 undefined opcode flags err", 64'(err), 1);
    cyc(); cyc();
    chk(err == 1, "R11 err sticky", 64'(err), 1);
    do_reset();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule